// File: doc/BRIEF.md
# ADC Result Window Watchdog

This block sits beside an ADC and watches every finished conversion. A small pool of watchdogs each hold an upper and a lower limit. Each input channel carries an enable bit and a 4-bit select field that names the watchdog whose limits apply to it. Many channels may point at the same watchdog and share its limits. A result above the upper limit or below the lower limit sets a sticky violation flag belonging to that watchdog.

Each watchdog has two flags, one for a high violation and one for a low violation. Each flag has its own mask bit. The single interrupt line is raised when any flag is set together with its mask bit. Software reaches the limits, selects, enables, masks and flags through a simple word-wide write port and a registered read port. The mask register and the flag register hold only two bits per implemented watchdog.

Top module: `adcwd_unit`

## Requirements
- R1: After reset, every upper limit reads as all ones (0xFFF with 12-bit data) and every lower limit reads as zero. Enables, masks and flags read as zero, and `irq` is low.
- R2: If an enabled channel's result is strictly greater than the upper limit of its selected watchdog k, flag bit 2k+1 is set. A strobe sampled on clock edge E makes the flag visible after edge E+1. Back-to-back strobes are each evaluated.
- R3: If an enabled channel's result is strictly less than the lower limit of its selected watchdog k, flag bit 2k is set. A result equal to either limit sets no flag.
- R4: A conversion on a channel whose enable bit is clear changes no flag. Enable bit c belongs to channel c.
- R5: Several channels may select the same watchdog and then share its limits. A channel whose select value is at or above the implemented watchdog count (6 by default) changes no flag.
- R6: The mask register keeps only its lowest 2×N bits, where N is the watchdog count. Bit 2k masks the low flag of watchdog k and bit 2k+1 masks its high flag. Upper bits ignore writes and read as zero.
- R7: Flags are sticky. Writing 1 to a bit at the flag address clears that bit, and writing 0 leaves it alone. When a clear and a set reach the same bit on the same edge, the set wins.
- R8: `irq` is the OR over all flag bits ANDed with their mask bits. It is registered, so it follows the flag register by one clock.
- R9: The register map is:
  - address 0x00: flags;
  - address 0x01: mask;
  - address 0x02: channel enables;
  - address 0x10+k: limits of watchdog k, with the lower limit in bits [15:0] and the upper limit in bits [31:16];
  - address 0x20+c: select of channel c, in bits [3:0].

  `reg_rdata` shows the register at `reg_addr` one clock later. Limits of a watchdog index at or above N ignore writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: a conversion result is present |
| conv_ch | input | 4 | Channel number of the result |
| conv_data | input | 12 | Conversion result |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address, for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of `reg_addr` |
| wdg_flags | output | 12 | Sticky violation flags; bit 2k is low and bit 2k+1 is high for watchdog k |
| irq | output | 1 | Masked OR of the flags |

## Verification
The hardest case to reach is a software clear that lands on the very edge where a new violation of the same watchdog is being recorded. The bench produces it by pulsing the conversion strobe and then issuing the clear write in the next cycle, so both meet at the comparison edge. Back-to-back strobes on two channels that share one watchdog also exercise the capture stage. Results exactly at a limit, an out-of-range select, a disabled channel, and writes into the unimplemented mask bits cover the remaining corner cases.

// File: rtl/adcwd_pkg.sv
package adcwd_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;
  localparam int SEL_W  = 4;

  localparam logic [ADDR_W-1:0] A_FLAGS = 8'h00;
  localparam logic [ADDR_W-1:0] A_MASK  = 8'h01;
  localparam logic [ADDR_W-1:0] A_EN    = 8'h02;
  localparam logic [3:0]        G_THR   = 4'h1;
  localparam logic [3:0]        G_SEL   = 4'h2;

  typedef enum logic [2:0] {
    RG_NONE, RG_FLAGS, RG_MASK, RG_EN, RG_THR, RG_SEL
  } rgroup_e;

  function automatic rgroup_e decode(input logic [ADDR_W-1:0] a);
    if (a == A_FLAGS)        return RG_FLAGS;
    else if (a == A_MASK)    return RG_MASK;
    else if (a == A_EN)      return RG_EN;
    else if (a[7:4] == G_THR) return RG_THR;
    else if (a[7:4] == G_SEL) return RG_SEL;
    else                     return RG_NONE;
  endfunction
endpackage

// File: rtl/adcwd_regs.sv
module adcwd_regs
  import adcwd_pkg::*;
#(
  parameter int NUM_WDG = 6,
  parameter int NUM_CH  = 16,
  parameter int DATA_W  = 12
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [REG_W-1:0]                wdata,
  input  logic [2*NUM_WDG-1:0]            flags_i,
  output logic [NUM_WDG-1:0][DATA_W-1:0]  thr_hi_o,
  output logic [NUM_WDG-1:0][DATA_W-1:0]  thr_lo_o,
  output logic [NUM_CH-1:0][SEL_W-1:0]    sel_o,
  output logic [NUM_CH-1:0]               en_o,
  output logic [2*NUM_WDG-1:0]            mask_o,
  output logic [2*NUM_WDG-1:0]            clr_o,
  output logic [REG_W-1:0]                rdata_o
);
  localparam int FW = 2 * NUM_WDG;

  rgroup_e          grp;
  logic [3:0]       idx;
  logic [REG_W-1:0] rd_next;
  logic             unused_wbits;

  assign grp          = decode(addr);
  assign idx          = addr[3:0];
  assign unused_wbits = ^wdata;

  assign clr_o = (wr && grp == RG_FLAGS) ? wdata[FW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '0;
      en_o   <= '0;
    end else if (wr) begin
      if (grp == RG_MASK) mask_o <= wdata[FW-1:0];
      if (grp == RG_EN)   en_o   <= wdata[NUM_CH-1:0];
    end
  end

  for (genvar k = 0; k < NUM_WDG; k++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst) begin
        thr_hi_o[k] <= '1;
        thr_lo_o[k] <= '0;
      end else if (wr && grp == RG_THR && idx == 4'(k)) begin
        thr_lo_o[k] <= wdata[DATA_W-1:0];
        thr_hi_o[k] <= wdata[16 +: DATA_W];
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst)
        sel_o[c] <= '0;
      else if (wr && grp == RG_SEL && idx == 4'(c))
        sel_o[c] <= wdata[SEL_W-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    case (grp)
      RG_FLAGS: rd_next[FW-1:0]     = flags_i;
      RG_MASK:  rd_next[FW-1:0]     = mask_o;
      RG_EN:    rd_next[NUM_CH-1:0] = en_o;
      RG_THR: begin
        for (int k = 0; k < NUM_WDG; k++) begin
          if (idx == 4'(k)) begin
            rd_next[DATA_W-1:0]  = thr_lo_o[k];
            rd_next[16 +: DATA_W] = thr_hi_o[k];
          end
        end
      end
      RG_SEL: begin
        for (int c = 0; c < NUM_CH; c++)
          if (idx == 4'(c)) rd_next[SEL_W-1:0] = sel_o[c];
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_next;
  end

  // R6: bits above the implemented mask width never show on a mask read
  assert_mask_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (addr == A_MASK) |=> ((rdata_o >> FW) == '0));
endmodule

// File: rtl/adcwd_cmp.sv
module adcwd_cmp
  import adcwd_pkg::*;
#(
  parameter int NUM_WDG = 6,
  parameter int NUM_CH  = 16,
  parameter int DATA_W  = 12,
  parameter int CH_W    = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            conv_done,
  input  logic [CH_W-1:0]                 conv_ch,
  input  logic [DATA_W-1:0]               conv_data,
  input  logic [NUM_WDG-1:0][DATA_W-1:0]  thr_hi_i,
  input  logic [NUM_WDG-1:0][DATA_W-1:0]  thr_lo_i,
  input  logic [NUM_CH-1:0][SEL_W-1:0]    sel_i,
  input  logic [NUM_CH-1:0]               en_i,
  output logic [2*NUM_WDG-1:0]            set_o
);
  logic              s1_v;
  logic [CH_W-1:0]   s1_ch;
  logic [DATA_W-1:0] s1_data;
  logic              ch_ok;
  logic [SEL_W-1:0]  cur_sel;
  logic              cur_en;
  logic              sel_ok;
  logic              active;
  logic [NUM_WDG-1:0] hit_hi;
  logic [NUM_WDG-1:0] hit_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_ch   <= '0;
      s1_data <= '0;
    end else begin
      s1_v <= conv_done;
      if (conv_done) begin
        s1_ch   <= conv_ch;
        s1_data <= conv_data;
      end
    end
  end

  always_comb begin
    ch_ok   = (int'(s1_ch) < NUM_CH);
    cur_sel = '0;
    cur_en  = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (s1_ch == CH_W'(c)) begin
        cur_sel = sel_i[c];
        cur_en  = en_i[c];
      end
    end
    sel_ok = (int'(cur_sel) < NUM_WDG);
    active = s1_v && ch_ok && cur_en && sel_ok;
  end

  for (genvar k = 0; k < NUM_WDG; k++) begin : g_win
    assign hit_hi[k] = active && (cur_sel == SEL_W'(k)) && (s1_data > thr_hi_i[k]);
    assign hit_lo[k] = active && (cur_sel == SEL_W'(k)) && (s1_data < thr_lo_i[k]);
    assign set_o[2*k]   = hit_lo[k];
    assign set_o[2*k+1] = hit_hi[k];
  end

  // R2: one result can only exceed the upper limit of a single watchdog
  assert_single_high_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_hi));
  // R3: likewise at most one low violation per result
  assert_single_low_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_lo));
  // R4: a captured result from a disabled channel raises nothing
  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (s1_v && !cur_en) |-> (set_o == '0));
  // R5: an out-of-range select raises nothing
  assert_bad_select_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (s1_v && int'(cur_sel) >= NUM_WDG) |-> (set_o == '0));
endmodule

// File: rtl/adcwd_flags.sv
module adcwd_flags #(
  parameter int NUM_WDG = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2*NUM_WDG-1:0] set_i,
  input  logic [2*NUM_WDG-1:0] clr_i,
  input  logic [2*NUM_WDG-1:0] mask_i,
  output logic [2*NUM_WDG-1:0] flags_o,
  output logic                 irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      flags_o <= (flags_o & ~clr_i) | set_i;
      irq_o   <= |(flags_o & mask_i);
    end
  end

  // R7: without a clear, no flag ever drops
  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_i == '0) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
  // R7: a set bit is present after the edge even if cleared on it
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));
  // R8: interrupt follows the masked flags one clock later
  assert_irq_low_R8: assert property (@(posedge clk) disable iff (rst)
    ((flags_o & mask_i) == '0) |=> !irq_o);
  assert_irq_high_R8: assert property (@(posedge clk) disable iff (rst)
    ((flags_o & mask_i) != '0) |=> irq_o);
endmodule

// File: rtl/adcwd_unit.sv
module adcwd_unit
  import adcwd_pkg::*;
#(
  parameter int NUM_WDG = 6,
  parameter int NUM_CH  = 16,
  parameter int DATA_W  = 12,
  parameter int CH_W    = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   conv_done,
  input  logic [CH_W-1:0]        conv_ch,
  input  logic [DATA_W-1:0]      conv_data,
  input  logic                   reg_wr,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [REG_W-1:0]       reg_wdata,
  output logic [REG_W-1:0]       reg_rdata,
  output logic [2*NUM_WDG-1:0]   wdg_flags,
  output logic                   irq
);
  localparam int FW = 2 * NUM_WDG;

  logic [NUM_WDG-1:0][DATA_W-1:0] thr_hi;
  logic [NUM_WDG-1:0][DATA_W-1:0] thr_lo;
  logic [NUM_CH-1:0][SEL_W-1:0]   sel;
  logic [NUM_CH-1:0]              en;
  logic [FW-1:0]                  mask;
  logic [FW-1:0]                  clr;
  logic [FW-1:0]                  set;

  adcwd_regs #(.NUM_WDG(NUM_WDG), .NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .flags_i(wdg_flags), .thr_hi_o(thr_hi), .thr_lo_o(thr_lo), .sel_o(sel),
    .en_o(en), .mask_o(mask), .clr_o(clr), .rdata_o(reg_rdata)
  );

  adcwd_cmp #(.NUM_WDG(NUM_WDG), .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_cmp (
    .clk(clk), .rst(rst), .conv_done(conv_done), .conv_ch(conv_ch),
    .conv_data(conv_data), .thr_hi_i(thr_hi), .thr_lo_i(thr_lo),
    .sel_i(sel), .en_i(en), .set_o(set)
  );

  adcwd_flags #(.NUM_WDG(NUM_WDG)) u_flags (
    .clk(clk), .rst(rst), .set_i(set), .clr_i(clr), .mask_i(mask),
    .flags_o(wdg_flags), .irq_o(irq)
  );
endmodule

// File: tb/adcwd_unit_bench.sv
module adcwd_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 6;
  localparam int NC = 16;
  localparam int DW = 12;
  localparam int FW = 2 * NW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          conv_done = 1'b0;
  logic [3:0]    conv_ch = '0;
  logic [DW-1:0] conv_data = '0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [FW-1:0] wdg_flags;
  logic          irq;

  adcwd_unit u_adcwd_unit (
    .clk(clk), .rst(rst), .conv_done(conv_done), .conv_ch(conv_ch),
    .conv_data(conv_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wdg_flags(wdg_flags), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; bit is_irq; logic [31:0] val; string req; } item_t;
  item_t exp_q[$];

  logic [DW-1:0] m_hi [NW];
  logic [DW-1:0] m_lo [NW];
  int            m_sel [NC];
  logic [NC-1:0] m_en;
  logic [FW-1:0] m_mask;
  logic [FW-1:0] m_flags;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      item_t it;
      it = exp_q.pop_front();
      if (it.is_irq) chk(it.req, {31'b0, irq}, it.val);
      else           chk(it.req, {20'b0, wdg_flags}, it.val);
    end
  end

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [7:0] a, logic [31:0] exp, string req);
    reg_addr = a;
    @(negedge clk);
    chk(req, reg_rdata, exp);
  endtask

  task automatic set_thr(int k, logic [DW-1:0] hi, logic [DW-1:0] lo);
    reg_write(8'h10 + 8'(k), {16'(hi), 16'(lo)});
    if (k < NW) begin m_hi[k] = hi; m_lo[k] = lo; end
  endtask

  task automatic set_sel(int c, int s);
    reg_write(8'h20 + 8'(c), 32'(s));
    m_sel[c] = s & 15;
  endtask

  task automatic clear_flags(logic [FW-1:0] bits);
    reg_write(8'h00, 32'(bits));
    m_flags = m_flags & ~bits;
  endtask

  // driver: one strobe, expected flags and irq pushed into the scoreboard
  task automatic convert(int ch, logic [DW-1:0] d, string req);
    logic [FW-1:0] s;
    s = '0;
    if (m_en[ch] && m_sel[ch] < NW) begin
      if (d > m_hi[m_sel[ch]]) s[2*m_sel[ch]+1] = 1'b1;
      if (d < m_lo[m_sel[ch]]) s[2*m_sel[ch]]   = 1'b1;
    end
    m_flags = m_flags | s;
    conv_done = 1'b1; conv_ch = 4'(ch); conv_data = d;
    exp_q.push_back('{cyc + 2, 1'b0, 32'(m_flags), req});
    exp_q.push_back('{cyc + 3, 1'b1, 32'(|(m_flags & m_mask)), {req, " irq R8"}});
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NW; k++) begin m_hi[k] = '1; m_lo[k] = '0; end
    for (int c = 0; c < NC; c++) m_sel[c] = 0;
    m_en = '0; m_mask = '0; m_flags = '0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 flags after reset", {20'b0, wdg_flags}, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    reg_read(8'h10, 32'h0FFF_0000, "R1 limits of watchdog 0");
    reg_read(8'h15, 32'h0FFF_0000, "R1 limits of watchdog 5");
    reg_read(8'h01, 32'h0, "R1 mask");
    reg_read(8'h02, 32'h0, "R1 enables");

    // configuration
    set_thr(0, 12'd800, 12'd200);
    set_thr(1, 12'd3000, 12'd1000);
    set_thr(5, 12'd100, 12'd50);
    set_thr(6, 12'd5, 12'd4);
    set_sel(9, 0); set_sel(3, 0); set_sel(4, 1); set_sel(7, 5); set_sel(10, 7);
    m_en = 16'h0698;
    reg_write(8'h02, 32'h0000_0698);
    m_mask = 12'h00F;
    reg_write(8'h01, 32'h0000_000F);

    reg_read(8'h10, {16'd800, 16'd200}, "R9 limits readback");
    reg_read(8'h16, 32'h0, "R9 unimplemented watchdog limits ignored");
    reg_read(8'h24, 32'h1, "R9 select readback");
    reg_read(8'h02, 32'h0000_0698, "R9 enable readback");

    // R2 high violation, R3 equality
    convert(9, 12'd800, "R3 equal to upper limit");
    idle(4);
    convert(9, 12'd801, "R2 above upper limit");
    idle(4);
    convert(3, 12'd200, "R3 equal to lower limit");
    idle(4);
    convert(3, 12'd199, "R3 R5 shared window low");
    idle(4);

    // R7 clear
    clear_flags(12'h003);
    chk("R7 write-one clear", {20'b0, wdg_flags}, 32'(m_flags));
    idle(1);
    chk("R8 irq drops after clear", {31'b0, irq}, 32'(|(m_flags & m_mask)));

    convert(4, 12'd999, "R3 watchdog 1 low");
    idle(4);
    convert(4, 12'd3001, "R2 watchdog 1 high");
    idle(4);
    clear_flags(12'h004);
    chk("R7 partial clear keeps others", {20'b0, wdg_flags}, 32'(m_flags));

    convert(10, 12'd4095, "R5 out-of-range select ignored");
    idle(4);
    convert(2, 12'd4000, "R4 disabled channel ignored");
    idle(4);
    clear_flags('1);
    idle(1);

    convert(7, 12'd101, "R8 masked flag keeps irq low");
    idle(4);
    reg_write(8'h01, 32'hFFFF_FFFF);
    m_mask = '1;
    reg_read(8'h01, 32'h0000_0FFF, "R6 upper mask bits read zero");
    idle(1);
    chk("R8 irq after unmask", {31'b0, irq}, 32'h1);
    clear_flags('1);
    idle(2);
    chk("R8 irq low with no flags", {31'b0, irq}, 32'h0);

    // R7 set and clear on the same edge
    convert(9, 12'd1000, "R7 set wins over clear");
    reg_write(8'h00, 32'h0000_0002);
    idle(4);
    chk("R7 flag still set after collision", {20'b0, wdg_flags}, 32'h2);
    clear_flags('1);
    idle(2);

    // R2 back-to-back strobes on a shared watchdog
    convert(9, 12'd900, "R2 back-to-back first");
    convert(3, 12'd100, "R2 back-to-back second");
    idle(5);

    chk("R2 scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1;
    summary();
    $finish;
  end
endmodule